// File: doc/BRIEF.md
# Edge-Interval Serial Byte Receiver

This block receives asynchronous serial bytes in the 8N1 format: one low start cell, eight data cells with the least significant bit first, and one high stop cell. It does not pick bit centres by oversampling. Instead, a free-running timestamp counter marks every transition of the synchronized line. The time since the start edge is rounded to a whole number of bit cells at each transition, and every cell between the previous boundary and the new one is filled with the level the line held during that run.

Cells are always rounded from the start edge, not from the previous edge, so small timing errors on successive edges do not add up. Cells after the last transition are filled when the middle of the stop cell is reached. At that point the block reports either a good byte or a framing error. The bit period is a run-time input in clock cycles, wide enough for slow rates such as 1200 baud on a fast core clock.

Top module: `edge_run_uart_rx`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `rx_valid` and `rx_frame_err` are 0 and `rx_byte` is 0x00.
- R2: A line held high produces no outcome. From idle, a falling edge starts a frame, and that edge is the leading edge of the start cell (cell 0).
- R3: Cells 1 to 8 carry data bits 0 to 7, so the least significant bit comes first. A frame with a high stop cell presents its byte on `rx_byte` with `rx_valid` high for exactly one cycle.
- R4: Each transition is placed at the nearest whole cell count from the start edge, found as floor((elapsed + P/2) / P). An offset of up to P/2-2 cycles, early or late, on any cell boundary therefore still gives the right byte.
- R5: When no transition follows the last run, the remaining cells up to and including the stop cell take the level the line holds. This is how trailing ones (for example 0xFF or 0x7F) are decoded.
- R6: If the line is low in the stop cell, `rx_frame_err` is high for one cycle, `rx_valid` stays low and `rx_byte` keeps its previous value.
- R7: The outcome appears between 9P + P/2 and 9P + P/2 + 8 clock cycles after the start edge reaches the pin.
- R8: Any bit period P from 8 to 2^BPW - 1 cycles works (BPW = 18, which covers 208 334 cycles, that is 1200 baud at 250 MHz), including odd values.
- R9: A low pulse shorter than P/2 on an idle line gives neither a byte nor a framing error, because its start cell rounds to high.
- R10: A new start edge exactly 10P after the previous one, with no idle gap, is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| period_cycles | input | BPW (18) | Bit period P in clock cycles, at least 8 |
| rx_byte | output | 8 | Last correctly received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |
| rx_frame_err | output | 1 | One-cycle pulse when the stop cell is low |

## Verification
Directed bytes cover the run shapes that decoding has to tell apart:
- 0x00 has one long low run that ends at the stop cell.
- 0xFF has a start cell only, followed by a single high run that is filled at the stop point.
- 0x55 has an edge at every boundary.
- 0x80 and 0x7F each have one long run in opposite polarities.

The same 0x55 frame is also sent with boundaries moved by the largest allowed offset, in alternating directions, to show that the rounding from the start edge absorbs the offset.

Random bytes with random odd and even periods and random per-boundary offsets check rounding against a reference computed in the bench. Further cases are a frame with a low stop cell, a short glitch, back-to-back frames and one long period; together they separate framing errors, noise rejection and frames that arrive with no idle gap.

// File: rtl/erx_pkg.sv
package erx_pkg;
  localparam int unsigned CELLS = 10;
  localparam int unsigned STOP_CELL = CELLS - 1;
  typedef logic [3:0] cell_idx_t;
  typedef enum logic {ST_IDLE, ST_BUSY} erx_state_e;
endpackage

// File: rtl/erx_sync_edge.sv
module erx_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din_i,
  output logic line_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      held_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din_i};
      held_q  <= chain_q[STAGES-1];
    end
  end

  assign line_o = held_q;
  assign rise_o = chain_q[STAGES-1] & ~held_q;
  assign fall_o = ~chain_q[STAGES-1] & held_q;
endmodule

// File: rtl/erx_tstamp.sv
module erx_tstamp #(
  parameter int unsigned TW = 22
) (
  input  logic          clk,
  input  logic          rst,
  output logic [TW-1:0] ts_o
);
  always_ff @(posedge clk) begin
    if (rst) ts_o <= '0;
    else     ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/erx_cell_round.sv
module erx_cell_round
  import erx_pkg::*;
#(
  parameter int unsigned TW   = 22,
  parameter int unsigned BPW  = 18,
  parameter int unsigned MAXC = 9
) (
  input  logic [TW-1:0]  elapsed_i,
  input  logic [BPW-1:0] period_i,
  output cell_idx_t      cells_o,
  output logic [TW-1:0]  stop_mark_o
);
  logic [TW-1:0]   per_w, half_w, biased;
  logic [MAXC-1:0] reached;

  assign per_w  = TW'(period_i);
  assign half_w = TW'(period_i >> 1);
  assign biased = elapsed_i + half_w;

  for (genvar k = 1; k <= MAXC; k++) begin : g_mark
    logic [TW-1:0] mark;
    assign mark         = per_w * TW'(k);
    assign reached[k-1] = (biased >= mark);
  end

  always_comb begin
    cells_o = '0;
    for (int i = 0; i < int'(MAXC); i++) cells_o = cells_o + cell_idx_t'(reached[i]);
  end

  assign stop_mark_o = per_w * TW'(MAXC) + half_w;
endmodule

// File: rtl/erx_frame.sv
module erx_frame
  import erx_pkg::*;
#(
  parameter int unsigned TW = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic [TW-1:0] ts_i,
  input  cell_idx_t     cells_i,
  input  logic [TW-1:0] stop_mark_i,
  output logic [TW-1:0] elapsed_o,
  output logic [7:0]    data_o,
  output logic          valid_o,
  output logic          err_o
);
  erx_state_e       state_q;
  logic [TW-1:0]    t0_q;
  cell_idx_t        done_q, lim;
  logic [CELLS-1:0] cellv_q, nxt;
  logic             busy, timeout, edge_seen;

  assign busy      = (state_q == ST_BUSY);
  assign elapsed_o = ts_i - t0_q;
  assign timeout   = busy && (elapsed_o >= stop_mark_i);
  assign edge_seen = rise_i | fall_i;
  assign lim       = timeout ? cell_idx_t'(CELLS) : cells_i;

  always_comb begin
    for (int i = 0; i < int'(CELLS); i++) begin
      if (cell_idx_t'(i) >= done_q && cell_idx_t'(i) < lim) nxt[i] = line_i;
      else                                                  nxt[i] = cellv_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      t0_q    <= '0;
      done_q  <= '0;
      cellv_q <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      if (!busy) begin
        if (fall_i) begin
          state_q <= ST_BUSY;
          t0_q    <= ts_i;
          done_q  <= '0;
        end
      end else if (timeout) begin
        state_q <= ST_IDLE;
        if (!nxt[0]) begin
          if (nxt[STOP_CELL]) begin
            valid_o <= 1'b1;
            data_o  <= nxt[8:1];
          end else begin
            err_o <= 1'b1;
          end
        end
      end else if (edge_seen) begin
        cellv_q <= nxt;
        done_q  <= cells_i;
      end
    end
  end

  // R2: a falling edge in idle opens a frame on the next cycle
  p_idle_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && fall_i) |=> busy);
  // R4: rounded boundaries never move backwards within a frame
  p_cells_mono_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && edge_seen && !timeout) |-> (cells_i >= done_q));
  // R5: a good byte needs the line high at the stop point
  p_valid_stop_r5: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(line_i));
  // R6: a framing error needs the line low at the stop point, never both outcomes
  p_err_stop_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!$past(line_i) && !valid_o));
  // R7: a frame never outlives the middle of its stop cell
  p_timeout_bound_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (elapsed_o <= stop_mark_i));
endmodule

// File: rtl/edge_run_uart_rx.sv
module edge_run_uart_rx
  import erx_pkg::*;
#(
  parameter int unsigned BPW         = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           serial_in,
  input  logic [BPW-1:0] period_cycles,
  output logic [7:0]     rx_byte,
  output logic           rx_valid,
  output logic           rx_frame_err
);
  localparam int unsigned TW = BPW + 4;

  logic          line, rise, fall;
  logic [TW-1:0] ts, elapsed, stop_mark;
  cell_idx_t     cells;

  erx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din_i(serial_in),
    .line_o(line), .rise_o(rise), .fall_o(fall)
  );

  erx_tstamp #(.TW(TW)) u_ts (.clk(clk), .rst(rst), .ts_o(ts));

  erx_cell_round #(.TW(TW), .BPW(BPW), .MAXC(STOP_CELL)) u_round (
    .elapsed_i(elapsed), .period_i(period_cycles),
    .cells_o(cells), .stop_mark_o(stop_mark)
  );

  erx_frame #(.TW(TW)) u_frame (
    .clk(clk), .rst(rst), .line_i(line), .rise_i(rise), .fall_i(fall),
    .ts_i(ts), .cells_i(cells), .stop_mark_i(stop_mark),
    .elapsed_o(elapsed), .data_o(rx_byte), .valid_o(rx_valid), .err_o(rx_frame_err)
  );
endmodule

// File: tb/edge_run_uart_rx_tb.sv
module edge_run_uart_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx  = 1'b1;
  logic [17:0] per = 18'd20;
  logic [7:0]  rx_byte;
  logic        rx_valid, rx_frame_err;

  int total = 0, bad = 0, cyc = 0;
  int vcnt = 0, ecnt = 0, vcyc = 0;
  logic [7:0] vdata = 8'h00;

  edge_run_uart_rx dut_i (
    .clk(clk), .rst(rst), .serial_in(rx), .period_cycles(per),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && rx_valid) begin vcnt++; vdata = rx_byte; vcyc = cyc; end
    if (!rst && rx_frame_err) begin ecnt++; vcyc = cyc; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int stop_mark(input int p);
    return 9 * p + p / 2;
  endfunction

  // Drives one 10-cell frame; every boundary is moved by a random offset in [-jmax, jmax],
  // or by alternating +/-jmax when alt is set. Returns the cycle of the start edge.
  task automatic send_frame(input logic [7:0] b, input bit stop_hi, input int p,
                            input int jmax, input bit alt, input int gap, output int start);
    int bnd[10];
    logic [9:0] cv;
    cv = {stop_hi, b, 1'b0};
    per = p[17:0];
    for (int k = 1; k < 10; k++) begin
      int j;
      if (alt) j = (k % 2 == 0) ? jmax : -jmax;
      else     j = (jmax == 0) ? 0 : int'($urandom_range(2 * jmax)) - jmax;
      bnd[k] = k * p + j;
    end
    start = cyc;
    for (int t = 0; t < 10 * p; t++) begin
      int idx = 0;
      for (int k = 1; k < 10; k++) if (t >= bnd[k]) idx = k;
      rx = cv[idx];
      @(negedge clk);
    end
    rx = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame_check(input logic [7:0] b, input bit stop_hi, input int p,
                             input int jmax, input bit alt, input string tag);
    int v0, e0, st;
    logic [7:0] d0;
    v0 = vcnt; e0 = ecnt; d0 = rx_byte;
    send_frame(b, stop_hi, p, jmax, alt, p, st);
    if (stop_hi) begin
      chk(vcnt - v0 == 1 && ecnt == e0, {tag, " one valid"}, vcnt - v0, 1);
      chk(vdata == b, {tag, " data"}, vdata, b);
    end else begin
      chk(ecnt - e0 == 1 && vcnt == v0, {tag, " R6 one frame_err"}, ecnt - e0, 1);
      chk(rx_byte == d0, {tag, " R6 byte kept"}, rx_byte, d0);
    end
    chk(vcyc - st >= stop_mark(p) && vcyc - st <= stop_mark(p) + 8,
        {tag, " R7 outcome time"}, vcyc - st, stop_mark(p));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int st, v0, e0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(rx_valid == 0 && rx_frame_err == 0 && rx_byte == 0, "R1 in reset", rx_byte, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_valid == 0 && rx_frame_err == 0 && rx_byte == 0, "R1 after reset", rx_byte, 0);

    // R2: idle high line yields nothing
    repeat (500) @(negedge clk);
    chk(vcnt == 0 && ecnt == 0, "R2 idle silent", vcnt + ecnt, 0);

    // R3 / R5 directed run shapes
    frame_check(8'h55, 1'b1, 20, 0, 1'b0, "R3 0x55");
    frame_check(8'h00, 1'b1, 20, 0, 1'b0, "R3 0x00");
    frame_check(8'hFF, 1'b1, 20, 0, 1'b0, "R5 0xFF tail fill");
    frame_check(8'h7F, 1'b1, 21, 0, 1'b0, "R5 0x7F tail fill");
    frame_check(8'h80, 1'b1, 21, 0, 1'b0, "R3 0x80 msb");

    // R4 worst-case alternating boundary offsets
    frame_check(8'h55, 1'b1, 20, 8, 1'b1, "R4 max offset 0x55");
    frame_check(8'hA6, 1'b1, 33, 14, 1'b1, "R4 max offset odd P");

    // R6 low stop cell
    frame_check(8'h00, 1'b0, 24, 0, 1'b0, "R6 break");
    frame_check(8'h3C, 1'b0, 24, 5, 1'b0, "R6 low stop");

    // R9 short glitch
    v0 = vcnt; e0 = ecnt; per = 18'd40;
    rx = 1'b0; repeat (3) @(negedge clk);
    rx = 1'b1; repeat (500) @(negedge clk);
    chk(vcnt == v0 && ecnt == e0, "R9 glitch rejected", vcnt - v0 + ecnt - e0, 0);

    // R10 back-to-back frames with no gap
    v0 = vcnt;
    send_frame(8'hC3, 1'b1, 24, 3, 1'b0, 0, st);
    chk(vcnt - v0 == 1 && vdata == 8'hC3, "R10 first of pair", vdata, 8'hC3);
    send_frame(8'h5A, 1'b1, 24, 3, 1'b0, 30, st);
    chk(vcnt - v0 == 2 && vdata == 8'h5A, "R10 second of pair", vdata, 8'h5A);

    // R4 / R8 random bytes, periods and offsets
    for (int n = 0; n < 40; n++) begin
      int p = 8 + int'($urandom_range(56));
      logic [7:0] b = 8'($urandom());
      bit sh = ($urandom_range(5) != 0);
      frame_check(b, sh, p, p / 2 - 2, 1'b0, "R8 R4 random");
    end

    // R8 long odd period
    frame_check(8'h96, 1'b1, 5003, 2000, 1'b0, "R8 long period");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule